// File: doc/BRIEF.md
# Outbound MMIO Window Partition Decoder

This block sits on the outbound path of a host bridge. It takes a CPU-side MMIO address and checks it against one 32-bit-style window and a set of 64-bit-style windows. When the address hits a window, the block returns the PCIe address to issue and the partition number that owns the access. The partition number is later used for isolation, for example to freeze a misbehaving device.

The 32-bit window keeps the address bits below its size and replaces the bits above its size with a programmable upper value. Its range is split into 256 equal segments. A 256-entry table maps each segment to a partition. A 64-bit window forwards the address unchanged. If the window is segmented, its 256 segments give the partition number directly, so the segment index is the partition number. If it is unsegmented, one configured partition covers the whole window. When windows overlap, a fixed priority decides which one applies.

Windows, the segment table and the upper value are loaded through a single-cycle configuration write port. A write with an illegal window geometry is dropped and flagged. A lookup is a single-cycle request, and its response is registered one cycle later.

Top module: `mmio_win_decoder`

## Requirements
- R1: After reset all windows are disabled and the segment table is zero. `cfgErr` and `rspValid` are low, and any lookup misses.
- R2: A lookup presented with `reqValid` high in a cycle gives `rspValid` high in the next cycle, with the result for that address. `rspValid` is low in any cycle that follows a cycle without a request.
- R3: On a 64-bit window hit, `rspPcieAddr` equals the request address unchanged.
- R4: A segmented 64-bit window of size 2^s returns as partition the bits [s-1:s-8] of the request address. This is the window offset shifted right by s-8.
- R5: An unsegmented 64-bit window returns its configured partition for every address in its range.
- R6: On a 32-bit window hit of size 2^s, `rspPcieAddr` is (upper value with bits below s cleared) OR (request address bits below s). The partition is the segment table entry indexed by address bits [s-1:s-8].
- R7: The enabled 64-bit window with the lowest index wins over any other 64-bit window. Any enabled 64-bit window wins over the 32-bit window.
- R8: An address inside no enabled window gives `rspMiss`=1 and `rspHit`=0, with `rspWin`, `rspPe` and `rspPcieAddr` all zero.
- R9: A window write is rejected when its base is not aligned to its size. For the 32-bit window it is also rejected when the size log2 is outside 8..32. For a 64-bit window it is also rejected when the size log2 is outside 28..ADDR_W-1 or the index is not below NUM_WIN64. A rejected write leaves the stored state unchanged and raises `cfgErr` in the next cycle. An accepted write, a table write and an upper write leave `cfgErr` low.
- R10: `cfgKind` encodes 0 as the 32-bit window (base, size, enable), 1 as a segment table entry (index `cfgIdx`, partition `cfgPe`), 2 as a 64-bit window (index `cfgIdx`, base, size, enable, segmented, partition) and 3 as the upper value (taken from `cfgAddr`). `rspWin` reports 0..NUM_WIN64-1 for a 64-bit window and NUM_WIN64 (16) for the 32-bit window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgKind | input | 2 | Write target: 0 32-bit window, 1 segment entry, 2 64-bit window, 3 upper value |
| cfgIdx | input | 8 | 64-bit window index or segment table index |
| cfgAddr | input | ADDR_W | Window base, or upper value for kind 3 |
| cfgSizeLog2 | input | 6 | Window size as log2 of bytes |
| cfgEnable | input | 1 | Window enable |
| cfgSegmented | input | 1 | 64-bit window takes its partition from the segment index |
| cfgPe | input | 8 | Partition for an unsegmented window or a table entry |
| cfgErr | output | 1 | Previous cycle's write was rejected |
| reqValid | input | 1 | Lookup request |
| reqAddr | input | ADDR_W | CPU-side address to decode |
| rspValid | output | 1 | Lookup result valid |
| rspHit | output | 1 | Address matched an enabled window |
| rspMiss | output | 1 | Address matched no enabled window |
| rspWin | output | WIN_W | Winning window number |
| rspPe | output | 8 | Partition number |
| rspPcieAddr | output | ADDR_W | Address to issue on PCIe |

## Verification
Directed lookups are made into each window kind in turn. One lands in an unsegmented 64-bit window and one in a segmented 64-bit window, which separates a fixed partition from a partition taken from the address bits. One lands in the 32-bit window, which shows address replacement above the size and the table-based segment mapping. Stacked overlaps between two 64-bit windows and between a 64-bit window and the 32-bit window show the priority order, and disabling the winner shows the fall-back. Rejected writes (misaligned base, size too small or too large, index out of range) are each followed by a lookup that shows the old state survived. Random reconfiguration, with lookups aimed mostly inside programmed windows, mixes all cases against a bench model.

// File: rtl/mmiowin_pkg.sv
package mmiowin_pkg;
  localparam int SEG_BITS = 8;
  localparam int PE_W     = 8;
  localparam int IDX_W    = 8;
  localparam int SIZE_W   = 6;

  typedef enum logic [1:0] {
    KIND_WIN32  = 2'd0,
    KIND_SEGMAP = 2'd1,
    KIND_WIN64  = 2'd2,
    KIND_UPPER  = 2'd3
  } cfgKind_e;

  typedef struct packed {
    logic             wrWin32;
    logic             wrWin64;
    logic             wrSegMap;
    logic             wrUpper;
    logic [IDX_W-1:0] idx;
  } cfgStrobe_t;
endpackage

// File: rtl/mmiowin_cfg_ctrl.sv
module mmiowin_cfg_ctrl
  import mmiowin_pkg::*;
#(
  parameter int ADDR_W     = 50,
  parameter int NUM_WIN64  = 16,
  parameter int MIN64_LOG2 = 28,
  parameter int MAX32_LOG2 = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgKind,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [SIZE_W-1:0] cfgSizeLog2,
  output cfgStrobe_t        strobe,
  output logic              cfgErr
);
  localparam logic [SIZE_W-1:0] MIN32 = SIZE_W'(SEG_BITS);
  localparam logic [SIZE_W-1:0] MAX32 = SIZE_W'(MAX32_LOG2);
  localparam logic [SIZE_W-1:0] MIN64 = SIZE_W'(MIN64_LOG2);
  localparam logic [SIZE_W-1:0] MAX64 = SIZE_W'(ADDR_W - 1);
  localparam logic [IDX_W-1:0]  NWIN  = IDX_W'(NUM_WIN64);

  logic [ADDR_W-1:0] lowMask;
  logic              misaligned, ok32, ok64, reject;
  cfgKind_e          kind;

  always_comb begin
    lowMask    = ~({ADDR_W{1'b1}} << cfgSizeLog2);
    misaligned = |(cfgAddr & lowMask);
    ok32 = !misaligned && (cfgSizeLog2 >= MIN32) && (cfgSizeLog2 <= MAX32);
    ok64 = !misaligned && (cfgSizeLog2 >= MIN64) && (cfgSizeLog2 <= MAX64)
           && (cfgIdx < NWIN);
    kind   = cfgKind_e'(cfgKind);
    strobe = '0;
    strobe.idx = cfgIdx;
    reject = 1'b0;
    if (cfgWe) begin
      unique case (kind)
        KIND_WIN32:  if (ok32) strobe.wrWin32 = 1'b1; else reject = 1'b1;
        KIND_WIN64:  if (ok64) strobe.wrWin64 = 1'b1; else reject = 1'b1;
        KIND_SEGMAP: strobe.wrSegMap = 1'b1;
        KIND_UPPER:  strobe.wrUpper  = 1'b1;
        default:     reject = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgErr <= 1'b0;
    else       cfgErr <= reject;
  end
endmodule

// File: rtl/mmiowin_datapath.sv
module mmiowin_datapath
  import mmiowin_pkg::*;
#(
  parameter int ADDR_W    = 50,
  parameter int NUM_WIN64 = 16,
  parameter int WIN_W     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [SIZE_W-1:0] cfgSizeLog2,
  input  logic              cfgEnable,
  input  logic              cfgSegmented,
  input  logic [PE_W-1:0]   cfgPe,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspMiss,
  output logic [WIN_W-1:0]  rspWin,
  output logic [PE_W-1:0]   rspPe,
  output logic [ADDR_W-1:0] rspPcieAddr
);
  localparam int NUM_SEG = 1 << SEG_BITS;
  localparam logic [SIZE_W-1:0] SEG_SHIFT = SIZE_W'(SEG_BITS);

  // 64-bit window storage
  logic [ADDR_W-1:0] base64 [NUM_WIN64];
  logic [SIZE_W-1:0] size64 [NUM_WIN64];
  logic [PE_W-1:0]   pe64   [NUM_WIN64];
  logic [NUM_WIN64-1:0] en64, seg64, hit64;
  logic [PE_W-1:0]   peCand [NUM_WIN64];

  // 32-bit window storage
  logic [ADDR_W-1:0] base32, upper32;
  logic [SIZE_W-1:0] size32;
  logic              en32;
  logic [PE_W-1:0]   segMap [NUM_SEG];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_WIN64; gi++) begin : g_win64
      logic [ADDR_W-1:0]   winMask;
      logic [SEG_BITS-1:0] segIdx;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          base64[gi] <= '0;
          size64[gi] <= '0;
          pe64[gi]   <= '0;
          en64[gi]   <= 1'b0;
          seg64[gi]  <= 1'b0;
        end else if (strobe.wrWin64 && strobe.idx == IDX_W'(gi)) begin
          base64[gi] <= cfgAddr;
          size64[gi] <= cfgSizeLog2;
          pe64[gi]   <= cfgPe;
          en64[gi]   <= cfgEnable;
          seg64[gi]  <= cfgSegmented;
        end
      end

      always_comb begin
        winMask     = {ADDR_W{1'b1}} << size64[gi];
        hit64[gi]   = en64[gi] && (((reqAddr ^ base64[gi]) & winMask) == '0);
        segIdx      = SEG_BITS'(reqAddr >> (size64[gi] - SEG_SHIFT));
        peCand[gi]  = seg64[gi] ? PE_W'(segIdx) : pe64[gi];
      end
    end

    for (gi = 0; gi < NUM_SEG; gi++) begin : g_segmap
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          segMap[gi] <= '0;
        else if (strobe.wrSegMap && strobe.idx == IDX_W'(gi))
          segMap[gi] <= cfgPe;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      base32  <= '0;
      size32  <= '0;
      en32    <= 1'b0;
      upper32 <= '0;
    end else begin
      if (strobe.wrWin32) begin
        base32 <= cfgAddr;
        size32 <= cfgSizeLog2;
        en32   <= cfgEnable;
      end
      if (strobe.wrUpper) upper32 <= cfgAddr;
    end
  end

  // 32-bit window decode
  logic [ADDR_W-1:0]   mask32, pcie32;
  logic [SEG_BITS-1:0] seg32;
  logic                hit32;
  logic [PE_W-1:0]     pe32;

  always_comb begin
    mask32 = {ADDR_W{1'b1}} << size32;
    hit32  = en32 && (((reqAddr ^ base32) & mask32) == '0);
    seg32  = SEG_BITS'(reqAddr >> (size32 - SEG_SHIFT));
    pe32   = segMap[seg32];
    pcie32 = (upper32 & mask32) | (reqAddr & ~mask32);
  end

  // Fixed priority: ascending 64-bit index, then the 32-bit window
  logic              found;
  logic [WIN_W-1:0]  selWin;
  logic [PE_W-1:0]   selPe;
  logic [ADDR_W-1:0] selPcie;

  always_comb begin
    found   = 1'b0;
    selWin  = '0;
    selPe   = '0;
    selPcie = '0;
    for (int i = 0; i < NUM_WIN64; i++) begin
      if (!found && hit64[i]) begin
        found   = 1'b1;
        selWin  = WIN_W'(i);
        selPe   = peCand[i];
        selPcie = reqAddr;
      end
    end
    if (!found && hit32) begin
      found   = 1'b1;
      selWin  = WIN_W'(NUM_WIN64);
      selPe   = pe32;
      selPcie = pcie32;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspHit      <= 1'b0;
      rspMiss     <= 1'b0;
      rspWin      <= '0;
      rspPe       <= '0;
      rspPcieAddr <= '0;
    end else begin
      rspValid    <= reqValid;
      rspHit      <= reqValid && found;
      rspMiss     <= reqValid && !found;
      rspWin      <= (reqValid && found) ? selWin  : '0;
      rspPe       <= (reqValid && found) ? selPe   : '0;
      rspPcieAddr <= (reqValid && found) ? selPcie : '0;
    end
  end
endmodule

// File: rtl/mmio_win_decoder.sv
module mmio_win_decoder
  import mmiowin_pkg::*;
#(
  parameter int ADDR_W     = 50,
  parameter int NUM_WIN64  = 16,
  parameter int MIN64_LOG2 = 28,
  parameter int MAX32_LOG2 = 32,
  parameter int WIN_W      = $clog2(NUM_WIN64 + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgKind,
  input  logic [7:0]        cfgIdx,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [5:0]        cfgSizeLog2,
  input  logic              cfgEnable,
  input  logic              cfgSegmented,
  input  logic [7:0]        cfgPe,
  output logic              cfgErr,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspMiss,
  output logic [WIN_W-1:0]  rspWin,
  output logic [7:0]        rspPe,
  output logic [ADDR_W-1:0] rspPcieAddr
);
  cfgStrobe_t strobe;

  mmiowin_cfg_ctrl #(
    .ADDR_W(ADDR_W), .NUM_WIN64(NUM_WIN64),
    .MIN64_LOG2(MIN64_LOG2), .MAX32_LOG2(MAX32_LOG2)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgKind(cfgKind),
    .cfgIdx(cfgIdx), .cfgAddr(cfgAddr), .cfgSizeLog2(cfgSizeLog2),
    .strobe(strobe), .cfgErr(cfgErr)
  );

  mmiowin_datapath #(
    .ADDR_W(ADDR_W), .NUM_WIN64(NUM_WIN64), .WIN_W(WIN_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgAddr(cfgAddr),
    .cfgSizeLog2(cfgSizeLog2), .cfgEnable(cfgEnable),
    .cfgSegmented(cfgSegmented), .cfgPe(cfgPe),
    .reqValid(reqValid), .reqAddr(reqAddr), .rspValid(rspValid),
    .rspHit(rspHit), .rspMiss(rspMiss), .rspWin(rspWin),
    .rspPe(rspPe), .rspPcieAddr(rspPcieAddr)
  );
endmodule

// File: rtl/mmio_win_decoder_chk.sv
module mmio_win_decoder_chk #(
  parameter int ADDR_W    = 50,
  parameter int NUM_WIN64 = 16,
  parameter int WIN_W     = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWe,
  input logic [1:0]        cfgKind,
  input logic              cfgErr,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              rspValid,
  input logic              rspHit,
  input logic              rspMiss,
  input logic [WIN_W-1:0]  rspWin,
  input logic [7:0]        rspPe,
  input logic [ADDR_W-1:0] rspPcieAddr
);
  p_rsp_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (rspValid == $past(reqValid)));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!rspHit && !rspMiss));

  p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspMiss) |-> (!rspHit && rspPe == '0 && rspWin == '0 && rspPcieAddr == '0));

  p_pass_through_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit && rspWin < WIN_W'(NUM_WIN64)) |-> (rspPcieAddr == $past(reqAddr)));

  p_win_range_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit) |-> (rspWin <= WIN_W'(NUM_WIN64)));

  p_err_source_r9: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> ($past(cfgWe) && ($past(cfgKind) == 2'd0 || $past(cfgKind) == 2'd2)));
endmodule

bind mmio_win_decoder mmio_win_decoder_chk #(
  .ADDR_W(ADDR_W), .NUM_WIN64(NUM_WIN64), .WIN_W(WIN_W)
) chk_i (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgKind(cfgKind), .cfgErr(cfgErr),
  .reqValid(reqValid), .reqAddr(reqAddr), .rspValid(rspValid),
  .rspHit(rspHit), .rspMiss(rspMiss), .rspWin(rspWin), .rspPe(rspPe),
  .rspPcieAddr(rspPcieAddr)
);

// File: tb/mmio_win_decoder_tb_top.sv
`timescale 1ns/1ps
module mmio_win_decoder_tb_top;
  localparam int AW = 50;
  localparam int NW = 16;
  localparam logic [63:0] AWMASK = (64'd1 << AW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgKind = '0;
  logic [7:0] cfgIdx = '0;
  logic [AW-1:0] cfgAddr = '0;
  logic [5:0] cfgSizeLog2 = '0;
  logic cfgEnable = 1'b0, cfgSegmented = 1'b0;
  logic [7:0] cfgPe = '0;
  logic cfgErr;
  logic reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic rspValid, rspHit, rspMiss;
  logic [4:0] rspWin;
  logic [7:0] rspPe;
  logic [AW-1:0] rspPcieAddr;

  always #2 clk = ~clk;

  mmio_win_decoder dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgKind(cfgKind), .cfgIdx(cfgIdx),
    .cfgAddr(cfgAddr), .cfgSizeLog2(cfgSizeLog2), .cfgEnable(cfgEnable),
    .cfgSegmented(cfgSegmented), .cfgPe(cfgPe), .cfgErr(cfgErr),
    .reqValid(reqValid), .reqAddr(reqAddr), .rspValid(rspValid),
    .rspHit(rspHit), .rspMiss(rspMiss), .rspWin(rspWin), .rspPe(rspPe),
    .rspPcieAddr(rspPcieAddr)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model of the programmed state
  bit          m64En [NW];
  bit          m64Seg [NW];
  logic [63:0] m64Base [NW];
  int          m64Size [NW];
  logic [7:0]  m64Pe [NW];
  bit          m32En;
  logic [63:0] m32Base, mUpper;
  int          m32Size;
  logic [7:0]  mTable [256];

  function automatic logic [63:0] hiMask(input int s);
    return ~((64'd1 << s) - 64'd1);
  endfunction

  function automatic bit inWin(input logic [63:0] a, input logic [63:0] b, input int s);
    return ((a ^ b) & hiMask(s)) == 64'd0;
  endfunction

  function automatic void model(input logic [63:0] a, output bit hit, output int win,
                                output logic [7:0] pe, output logic [63:0] pcie);
    hit = 0; win = 0; pe = 0; pcie = 0;
    if (m32En && inWin(a, m32Base, m32Size)) begin
      hit = 1; win = NW;
      pe = mTable[(a >> (m32Size - 8)) & 64'hFF];
      pcie = ((mUpper & hiMask(m32Size)) | (a & ~hiMask(m32Size))) & AWMASK;
    end
    for (int i = NW - 1; i >= 0; i--) begin
      if (m64En[i] && inWin(a, m64Base[i], m64Size[i])) begin
        hit = 1; win = i; pcie = a;
        pe = m64Seg[i] ? 8'((a >> (m64Size[i] - 8)) & 64'hFF) : m64Pe[i];
      end
    end
  endfunction

  task automatic cfgWrite(input int kind, input int idx, input logic [63:0] addr,
                          input int size, input bit en, input bit seg,
                          input logic [7:0] pe, input string req);
    bit accept;
    bit misal;
    misal = (addr & ~hiMask(size)) != 64'd0;
    case (kind)
      0: accept = !misal && size >= 8 && size <= 32;
      2: accept = !misal && size >= 28 && size <= AW - 1 && idx < NW;
      default: accept = 1;
    endcase
    @(negedge clk);
    cfgWe = 1'b1; cfgKind = 2'(kind); cfgIdx = 8'(idx); cfgAddr = addr[AW-1:0];
    cfgSizeLog2 = 6'(size); cfgEnable = en; cfgSegmented = seg; cfgPe = pe;
    @(negedge clk);
    cfgWe = 1'b0;
    checks++;
    if (cfgErr !== !accept) begin
      failures++;
      $display("FAIL %s cfgErr kind=%0d idx=%0d: actual %0b expected %0b", req, kind, idx, cfgErr, !accept);
    end
    if (accept) begin
      case (kind)
        0: begin m32Base = addr; m32Size = size; m32En = en; end
        1: mTable[idx] = pe;
        2: begin m64Base[idx] = addr; m64Size[idx] = size; m64En[idx] = en;
                 m64Seg[idx] = seg; m64Pe[idx] = pe; end
        default: mUpper = addr & AWMASK;
      endcase
    end
  endtask

  task automatic lookup(input logic [63:0] a, input string req);
    bit eh; int ew; logic [7:0] ep; logic [63:0] ea;
    model(a & AWMASK, eh, ew, ep, ea);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a[AW-1:0];
    @(negedge clk);
    reqValid = 1'b0;
    checks++;
    if (rspValid !== 1'b1 || rspHit !== eh || rspMiss !== !eh || rspWin !== 5'(ew) ||
        rspPe !== ep || rspPcieAddr !== ea[AW-1:0]) begin
      failures++;
      $display("FAIL %s addr=%h: actual v=%0b h=%0b m=%0b win=%0d pe=%h pcie=%h expected v=1 h=%0b m=%0b win=%0d pe=%h pcie=%h",
               req, a, rspValid, rspHit, rspMiss, rspWin, rspPe, rspPcieAddr,
               eh, !eh, ew, ep, ea[AW-1:0]);
    end
  endtask

  task automatic checkIdle(input string req);
    @(negedge clk);
    checks++;
    if (rspValid !== 1'b0 || rspHit !== 1'b0 || rspMiss !== 1'b0) begin
      failures++;
      $display("FAIL %s idle response: actual v=%0b h=%0b m=%0b expected 0 0 0", req, rspValid, rspHit, rspMiss);
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    for (int i = 0; i < NW; i++) begin
      m64En[i] = 0; m64Seg[i] = 0; m64Base[i] = 0; m64Size[i] = 0; m64Pe[i] = 0;
    end
    for (int i = 0; i < 256; i++) mTable[i] = 0;
    m32En = 0; m32Base = 0; m32Size = 0; mUpper = 0;
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    @(negedge clk);
    checks++;
    if (cfgErr !== 1'b0 || rspValid !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset: actual cfgErr=%0b rspValid=%0b expected 0 0", cfgErr, rspValid);
    end
    lookup(64'h0000_8000_1234, "R1");
    lookup(64'h1_0000_0040, "R1");
    checkIdle("R2");

    // R5/R3: unsegmented 64-bit window 3
    cfgWrite(2, 3, 64'h1_0000_0000, 28, 1, 0, 8'h5A, "R10");
    lookup(64'h1_0ABC_DEF0, "R5");
    lookup(64'h1_0FFF_FFFF, "R3");
    lookup(64'h1_1000_0000, "R8");

    // R4: segmented 64-bit window 5, size 2^32, partition = addr[31:24]
    cfgWrite(2, 5, 64'h40_0000_0000, 32, 1, 1, 8'h00, "R10");
    lookup(64'h40_3712_3456, "R4");
    lookup(64'h40_FF00_0001, "R4");
    lookup(64'h40_0000_0000, "R4");

    // R6: 32-bit window 2GB at 0x8000_0000, 8MB segments
    cfgWrite(3, 0, 64'h3_ABCD_0000_0000, 0, 0, 0, 8'h00, "R10");
    cfgWrite(1, 8'h10, 64'h0, 0, 0, 0, 8'hC3, "R10");
    cfgWrite(1, 8'hFF, 64'h0, 0, 0, 0, 8'h7E, "R10");
    cfgWrite(0, 0, 64'h8000_0000, 31, 1, 0, 8'h00, "R10");
    lookup(64'h8000_0000 + (64'h10 << 23) + 64'h123, "R6");
    lookup(64'hFFFF_FFFF, "R6");
    lookup(64'h8000_0000, "R6");

    // R7: overlap priority
    cfgWrite(2, 1, 64'h1_0000_0000, 30, 1, 0, 8'h11, "R7");
    lookup(64'h1_0ABC_DEF0, "R7");
    cfgWrite(2, 0, 64'h0, 32, 1, 0, 8'h22, "R7");
    lookup(64'h8080_0000, "R7");
    cfgWrite(2, 0, 64'h0, 32, 0, 0, 8'h22, "R7");
    lookup(64'h8080_0000, "R7");
    cfgWrite(2, 1, 64'h1_0000_0000, 30, 0, 0, 8'h11, "R7");
    lookup(64'h1_0ABC_DEF0, "R7");

    // R9: rejected writes leave state untouched
    cfgWrite(2, 2, 64'h0800_0000, 28, 1, 0, 8'h33, "R9");
    lookup(64'h0800_0010, "R9");
    cfgWrite(2, 2, 64'h2_0000_0000, 27, 1, 0, 8'h33, "R9");
    lookup(64'h2_0000_0010, "R9");
    cfgWrite(0, 0, 64'h0, 33, 1, 0, 8'h00, "R9");
    lookup(64'h8000_0000 + (64'h10 << 23), "R9");
    cfgWrite(2, 16, 64'h2_0000_0000, 28, 1, 0, 8'h33, "R9");
    lookup(64'h2_0000_0010, "R9");
    cfgWrite(2, 3, 64'h1_0000_0000, AW, 1, 0, 8'h44, "R9");
    lookup(64'h1_0000_0100, "R9");
    checkIdle("R2");

    // random phase
    for (int r = 0; r < 60; r++) begin
      int k;
      k = $urandom % 10;
      if (k < 6) begin
        int s; int ix; logic [63:0] b;
        s = 28 + $urandom % 8;
        ix = $urandom % NW;
        b = rnd64() & AWMASK & hiMask(s);
        if ($urandom % 8 == 0) b = b | (64'd1 << ($urandom % s));
        cfgWrite(2, ix, b, s, ($urandom % 5) != 0, $urandom % 2, 8'($urandom), "R9");
      end else if (k < 8) begin
        int s; logic [63:0] b;
        s = 8 + $urandom % 25;
        b = rnd64() & AWMASK & hiMask(s);
        cfgWrite(0, 0, b, s, 1, 0, 8'h00, "R9");
      end else if (k < 9) begin
        cfgWrite(1, $urandom % 256, 64'h0, 0, 0, 0, 8'($urandom), "R10");
      end else begin
        cfgWrite(3, 0, rnd64() & AWMASK, 0, 0, 0, 8'h00, "R10");
      end
      for (int j = 0; j < 6; j++) begin
        logic [63:0] a;
        int w;
        w = $urandom % (NW + 2);
        if (w < NW && m64En[w])
          a = m64Base[w] | (rnd64() & ~hiMask(m64Size[w]));
        else if (w == NW && m32En)
          a = m32Base | (rnd64() & ~hiMask(m32Size));
        else
          a = rnd64();
        lookup(a & AWMASK, "R7");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule